// File: doc/BRIEF.md
# Supply Supervisor with Brownout Reset and Early-Warning Interrupt

This block watches two supply comparators and turns their raw levels into a clean system reset and a power-fail warning interrupt. The first comparator reports that the supply is below the reset threshold. The second reports that it is below a higher warning threshold. Both levels pass through a two-flop synchroniser before any logic uses them.

The reset side is a three-state machine. `ST_HOLD` keeps reset asserted while the supply is low. Transition `HOLD->COUNT` happens when the supply comes back above the reset threshold. `ST_COUNT` keeps reset asserted while a stabilisation counter runs. Transition `COUNT->RUN` happens when that counter reaches its final value. Transitions `COUNT->HOLD` and `RUN->HOLD` happen on any new brownout. In `ST_RUN` reset is released.

The warning side has two parts. A sticky flag records any warning condition, whether or not the interrupt is enabled, and only software can clear it. An interrupt request is raised when the warning first appears while the enable bit is set. The request is withdrawn on acknowledge, or when the enable is cleared. The interrupt vector is a fixed address output. This source is meant to sit at the top of the interrupt priority order.

Top module: `pwr_supervisor`

## Requirements
- R1: While the synchronised reset comparator is high, `sys_rst_o` is 1. A rising `below_rst_i` makes `sys_rst_o` 1 after the third rising clock edge; after the second edge it still shows its old value.
- R2: After `below_rst_i` falls, `sys_rst_o` stays 1 and goes to 0 after exactly STAB_CYCLES+3 rising edges (STAB_CYCLES defaults to 65536).
- R3: A brownout seen during the stabilisation count sends the machine back to `ST_HOLD`. The count restarts from zero, so release again takes STAB_CYCLES+3 edges from the final recovery.
- R4: `pf_flag_o` becomes 1 after the third rising edge following a rising `below_warn_i`, whether `irq_en_i` is 0 or 1.
- R5: `pf_flag_o` stays 1 until a one-cycle `flag_clr_i` pulse arrives while the synchronised warning is low. A clear that arrives while the warning is still present leaves the flag at 1.
- R6: `pf_irq_o` becomes 1 after the third edge following a rising `below_warn_i` only when `irq_en_i` is 1. With `irq_en_i` at 0 it stays 0.
- R7: A one-cycle `irq_ack_i` pulse clears `pf_irq_o` after the next edge, and so does a 0 on `irq_en_i`. Neither of these touches `pf_flag_o`.
- R8: `irq_vec_o` always equals the parameter VEC_ADDR, which defaults to 0x0033. After `arst_ni` is low, `sys_rst_o` is 1, while `pf_flag_o` and `pf_irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous power-on initialisation of the block's own flops, active low |
| below_rst_i | input | 1 | Raw comparator level, 1 = supply below reset threshold |
| below_warn_i | input | 1 | Raw comparator level, 1 = supply below warning threshold |
| irq_en_i | input | 1 | Software interrupt enable bit |
| flag_clr_i | input | 1 | One-cycle software write that clears the flag |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| sys_rst_o | output | 1 | System reset, active high |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| pf_flag_o | output | 1 | Sticky power-fail flag |
| irq_vec_o | output | VEC_W | Fixed interrupt vector address |

## Verification
The hardest case to reach is a brownout that lands inside the long stabilisation count. At that point the restart is invisible at the ports, because reset is already asserted. The stimulus brings the machine to `ST_RUN`, forces a brownout, and releases the supply. About a thousand cycles into the new count it injects a short glitch, then releases again. The cycle count to reset release is then measured from the final release: if the counter had not been cleared, reset would drop early.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } sup_state_e;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         arst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) stg_q[0] <= '0;
        else          stg_q[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i or negedge arst_ni) begin
            if (!arst_ni) stg_q[g] <= '0;
            else          stg_q[g] <= stg_q[g-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pwr_rst_fsm.sv
module pwr_rst_fsm
    import pwr_sup_pkg::*;
#(
    parameter int STAB_CYCLES = 65536
) (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic low_s_i,
    output logic rst_o
);
    localparam int CW = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

    sup_state_e      state_q, state_n;
    logic [CW-1:0]   cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD:  if (!low_s_i) state_n = ST_COUNT;
            ST_COUNT: begin
                if (low_s_i)            state_n = ST_HOLD;
                else if (cnt_q == LAST) state_n = ST_RUN;
            end
            ST_RUN:   if (low_s_i) state_n = ST_HOLD;
            default:  state_n = ST_HOLD;
        endcase
        cnt_n = (state_q == ST_COUNT && !low_s_i) ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  rst_o = 1'b0;
            default: rst_o = 1'b1;
        endcase
    end

    // R1
    low_hold_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        low_s_i |=> rst_o);
    // R2
    release_count_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $fell(rst_o) |-> ($past(cnt_q) == LAST));
    // R3
    restart_clear_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        low_s_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_warn_flag.sv
module pwr_warn_flag (
    input  logic clk_i,
    input  logic arst_ni,
    input  logic warn_s_i,
    input  logic en_i,
    input  logic clr_i,
    input  logic ack_i,
    output logic flag_o,
    output logic irq_o
);
    logic warn_d_q, flag_q, pend_q, warn_rise;

    assign warn_rise = warn_s_i & ~warn_d_q;

    always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) begin
            warn_d_q <= 1'b0;
            flag_q   <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            warn_d_q <= warn_s_i;
            if (warn_s_i)   flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
            if (warn_rise && en_i)   pend_q <= 1'b1;
            else if (ack_i || !en_i) pend_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = pend_q;

    // R4
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        warn_s_i |=> flag_o);
    // R5
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (flag_o && !clr_i) |=> flag_o);
    // R6
    irq_needs_en_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $rose(irq_o) |-> $past(en_i));
    // R7
    irq_drop_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        (irq_o && (!en_i || (ack_i && !warn_s_i))) |=> !irq_o);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
    parameter int          STAB_CYCLES = 65536,
    parameter int          SYNC_STAGES = 2,
    parameter int          VEC_W       = 16,
    parameter logic [15:0] VEC_ADDR    = 16'h0033
) (
    input  logic             clk_i,
    input  logic             arst_ni,
    input  logic             below_rst_i,
    input  logic             below_warn_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    input  logic             irq_ack_i,
    output logic             sys_rst_o,
    output logic             pf_irq_o,
    output logic             pf_flag_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    logic [1:0] cmp_s;

    pwr_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .d_i     ({below_warn_i, below_rst_i}),
        .q_o     (cmp_s)
    );

    pwr_rst_fsm #(.STAB_CYCLES(STAB_CYCLES)) u_fsm (
        .clk_i   (clk_i),
        .arst_ni (arst_ni),
        .low_s_i (cmp_s[0]),
        .rst_o   (sys_rst_o)
    );

    pwr_warn_flag u_warn (
        .clk_i    (clk_i),
        .arst_ni  (arst_ni),
        .warn_s_i (cmp_s[1]),
        .en_i     (irq_en_i),
        .clr_i    (flag_clr_i),
        .ack_i    (irq_ack_i),
        .flag_o   (pf_flag_o),
        .irq_o    (pf_irq_o)
    );

    assign irq_vec_o = VEC_W'(VEC_ADDR);

    // R8
    vec_fixed_chk: assert property (@(posedge clk_i) disable iff (!arst_ni)
        $stable(irq_vec_o));
endmodule

// File: tb/pwr_supervisor_tb.sv
module pwr_supervisor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 65536;
    localparam int WDOG       = 190000;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic below_rst = 1'b1, below_warn = 1'b0;
    logic irq_en = 1'b0, flag_clr = 1'b0, irq_ack = 1'b0;
    logic sys_rst, pf_irq, pf_flag;
    logic [15:0] irq_vec;
    int   n_run = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_supervisor u_dut (
        .clk_i(clk), .arst_ni(arst_n), .below_rst_i(below_rst),
        .below_warn_i(below_warn), .irq_en_i(irq_en), .flag_clr_i(flag_clr),
        .irq_ack_i(irq_ack), .sys_rst_o(sys_rst), .pf_irq_o(pf_irq),
        .pf_flag_o(pf_flag), .irq_vec_o(irq_vec)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_release(input string tag);
        int cyc = 0;
        while (sys_rst && cyc < N + 20) begin
            step(1);
            cyc++;
        end
        chk(tag, cyc, N + 3);
    endtask

    task automatic t_reset_state();
        step(2);
        chk("R8 rst during init", sys_rst, 1);
        chk("R8 flag during init", pf_flag, 0);
        chk("R8 irq during init", pf_irq, 0);
        chk("R8 vector", irq_vec, 16'h0033);
        arst_n = 1'b1;
    endtask

    task automatic t_powerup();
        for (int i = 0; i < 10; i++) begin
            step(1);
            chk("R1 hold while low", sys_rst, 1);
        end
        below_rst = 1'b0;
        count_release("R2 release cycles");
    endtask

    task automatic t_flag_no_en();
        irq_en = 1'b0;
        below_warn = 1'b1;
        step(2);
        chk("R4 flag not before sync", pf_flag, 0);
        step(1);
        chk("R4 flag set en=0", pf_flag, 1);
        step(3);
        chk("R6 no irq en=0", pf_irq, 0);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R5 clear ignored while warn", pf_flag, 1);
        below_warn = 1'b0;
        step(5);
        chk("R5 flag sticky", pf_flag, 1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R5 flag cleared", pf_flag, 0);
    endtask

    task automatic t_irq_en();
        irq_en = 1'b1;
        step(1);
        below_warn = 1'b1;
        step(2);
        chk("R6 irq not before sync", pf_irq, 0);
        step(1);
        chk("R6 irq raised", pf_irq, 1);
        chk("R4 flag set en=1", pf_flag, 1);
        below_warn = 1'b0;
        step(3);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        chk("R7 ack clears irq", pf_irq, 0);
        chk("R7 ack keeps flag", pf_flag, 1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R5 clear after ack", pf_flag, 0);
        below_warn = 1'b1;
        step(3);
        chk("R6 irq raised again", pf_irq, 1);
        irq_en = 1'b0; step(1);
        chk("R7 disable clears irq", pf_irq, 0);
        chk("R7 disable keeps flag", pf_flag, 1);
        below_warn = 1'b0;
        step(3);
    endtask

    task automatic t_brownout_restart();
        below_rst = 1'b1;
        step(2);
        chk("R1 rst not before sync", sys_rst, 0);
        step(1);
        chk("R1 rst on brownout", sys_rst, 1);
        step(5);
        below_rst = 1'b0;
        step(1000);
        chk("R3 still counting", sys_rst, 1);
        below_rst = 1'b1; step(3); below_rst = 1'b0;
        count_release("R3 restart cycles");
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_powerup();
        t_flag_no_en();
        t_irq_en();
        t_brownout_restart();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule